// File: doc/BRIEF.md
# IPv6 Extension Header Chain Checker

This receive-side block follows the chain of IPv6 extension headers in an incoming packet while the packet streams past one byte per clock. The first byte of a packet is marked with a start flag and the last with an end flag; a valid strobe qualifies every byte, so idle cycles may sit anywhere inside a packet. The block reads the next-header code in the fixed 40-byte base header. It then skips over hop-by-hop, routing and destination-options headers until it meets a code that is not one of those three.

Each packet produces one result. The result gives the upper-layer protocol class, the byte offset at which that payload begins, an error flag, and a flag that allows checksum handling. Ordering is enforced. A hop-by-hop header is legal only in the first position after the base header. Anywhere else it makes the packet invalid, even when the chain later reaches TCP, UDP or ICMPv6.

Top module: `ipv6_chain_walker`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `ptype_o`, `err_o`, `csum_ok_o` and `offset_o` are all zero.
- R2: Byte offsets count from 0 at the byte that carries `sof_i`. The base header's next-header code is the byte at offset 6, and the chain starts at offset 40. A direct code of 6, 17 or 58 gives a `ptype_o` of 1 (TCP), 2 (UDP) or 3 (ICMPv6), with `offset_o` = 40 and `err_o` = 0. `done_o` pulses high for one cycle in the cycle after the clock edge that accepts the byte at the payload offset.
- R3: Extension headers with codes 43 (routing) and 60 (destination options) may appear any number of times and in any order. Each one starts with the next code, has its length byte L in its second byte, and is (L+1)*8 bytes long. The reported offset is 40 plus the sum of all the header sizes.
- R4: A hop-by-hop header (code 0) placed directly after the base header is accepted and skipped like any other extension header.
- R5: A hop-by-hop header in any later position ends the walk at that header's first byte with `err_o` = 1 and `ptype_o` = 0.
- R6: A chain that ends in any other code gives `ptype_o` = 0 with `err_o` = 0. `csum_ok_o` is 1 only when `ptype_o` is nonzero and `err_o` is 0.
- R7: If `eof_i` arrives on a byte before the payload's first byte is reached, the result is issued on that byte with `err_o` = 1 and `ptype_o` = 0.
- R8: Cycles with `valid_i` low are ignored, including any `sof_i`, `eof_i` or data present in those cycles. They do not advance the byte offset.
- R9: Each packet gives exactly one `done_o` pulse. Bytes after the deciding byte are ignored until the next `sof_i`. A `sof_i` in the middle of a packet abandons that packet without any result. Result outputs change only on a `done_o` cycle and hold otherwise.
- R10: If a length byte would place the end of a header at or beyond offset 2^OFF_W-1, the walk ends on that length byte with `err_o` = 1.
- R11: Every error result reports `offset_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte qualifier |
| sof_i | input | 1 | First byte of a packet |
| eof_i | input | 1 | Last byte of a packet |
| data_i | input | 8 | Packet byte |
| done_o | output | 1 | One-cycle result strobe |
| ptype_o | output | 2 | 0 other, 1 TCP, 2 UDP, 3 ICMPv6 |
| err_o | output | 1 | Chain error (misplaced hop-by-hop, truncation, offset overflow) |
| csum_ok_o | output | 1 | Payload is eligible for checksum handling |
| offset_o | output | OFF_W | Payload start offset in bytes |

## Verification
The hardest case to reach from the ports is a hop-by-hop header that sits behind one or more legal headers. The walker must reject it even though the chain would otherwise continue to a valid transport code. A sweep builds every chain of up to three extension headers from the three legal codes, with varied lengths and four different terminal codes. This places code 0 at every depth and after every kind of predecessor. Idle gaps carrying misleading start and end marks are interleaved into half of the packets.

// File: rtl/ipv6_chain_pkg.sv
package ipv6_chain_pkg;
  localparam logic [7:0] NH_HOP   = 8'd0;
  localparam logic [7:0] NH_ROUTE = 8'd43;
  localparam logic [7:0] NH_DEST  = 8'd60;
  localparam logic [7:0] NH_TCP   = 8'd6;
  localparam logic [7:0] NH_UDP   = 8'd17;
  localparam logic [7:0] NH_ICMP  = 8'd58;
  localparam int BASE_LEN = 40;
  localparam int NH_OFF   = 6;

  typedef enum logic [1:0] {
    PT_OTHER = 2'd0,
    PT_TCP   = 2'd1,
    PT_UDP   = 2'd2,
    PT_ICMP  = 2'd3
  } ptype_e;

  typedef struct packed {
    logic   hop;
    logic   opt;
    ptype_e pt;
  } nh_class_t;
endpackage

// File: rtl/ipv6_byte_pos.sv
module ipv6_byte_pos #(
  parameter int OFF_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  output logic [OFF_W-1:0] pos_o
);
  localparam logic [OFF_W-1:0] MAX_POS = {OFF_W{1'b1}};

  logic [OFF_W-1:0] cnt_q;

  assign pos_o = sof_i ? '0 : cnt_q;

  // saturate so an oversize packet never wraps onto a header boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_i) cnt_q <= (pos_o == MAX_POS) ? MAX_POS : pos_o + 1'b1;
  end
endmodule

// File: rtl/ipv6_nh_classify.sv
module ipv6_nh_classify
  import ipv6_chain_pkg::*;
(
  input  logic [7:0] code_i,
  output nh_class_t  cls_o
);
  always_comb begin
    cls_o = '{hop: 1'b0, opt: 1'b0, pt: PT_OTHER};
    case (code_i)
      NH_HOP:   cls_o.hop = 1'b1;
      NH_ROUTE: cls_o.opt = 1'b1;
      NH_DEST:  cls_o.opt = 1'b1;
      NH_TCP:   cls_o.pt  = PT_TCP;
      NH_UDP:   cls_o.pt  = PT_UDP;
      NH_ICMP:  cls_o.pt  = PT_ICMP;
      default:  cls_o.pt  = PT_OTHER;
    endcase
  end
endmodule

// File: rtl/ipv6_chain_fsm.sv
module ipv6_chain_fsm
  import ipv6_chain_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic [7:0]       data_i,
  input  logic [OFF_W-1:0] pos_i,
  input  nh_class_t        cls_i,
  output logic [7:0]       nh_o,
  output logic             done_o,
  output ptype_e           ptype_o,
  output logic             err_o,
  output logic             csum_ok_o,
  output logic [OFF_W-1:0] offset_o
);
  localparam int               SUM_W   = (OFF_W >= 12) ? OFF_W + 1 : 13;
  localparam logic [OFF_W-1:0] MAX_POS = {OFF_W{1'b1}};
  localparam logic [OFF_W-1:0] BASE_POS = OFF_W'(BASE_LEN);
  localparam logic [OFF_W-1:0] NH_POS   = OFF_W'(NH_OFF);

  logic             busy_q, first_q, len_pend_q;
  logic [7:0]       nh_q;
  logic [OFF_W-1:0] bound_q;

  logic acc, cont, at_nh, at_bound, at_len;
  logic is_ext, hop_bad, ovf;
  logic fin_ok, fin_err, fin;
  logic [SUM_W-1:0] hdr_bytes, sum;

  assign acc      = valid_i && (busy_q || sof_i);
  assign cont     = acc && !sof_i;
  assign at_nh    = cont && (pos_i == NH_POS);
  assign at_bound = cont && !len_pend_q && (pos_i == bound_q);
  assign at_len   = cont && len_pend_q;

  assign is_ext  = cls_i.hop || cls_i.opt;
  assign hop_bad = cls_i.hop && !first_q;

  assign hdr_bytes = (SUM_W'(data_i) + SUM_W'(1)) << 3;
  assign sum       = SUM_W'(bound_q) + hdr_bytes;
  assign ovf       = sum >= SUM_W'(MAX_POS);

  assign fin_ok  = at_bound && !is_ext;
  assign fin_err = (at_bound && hop_bad) || (at_len && ovf) || (acc && eof_i && !fin_ok);
  assign fin     = fin_ok || fin_err;

  assign nh_o = nh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      first_q    <= 1'b0;
      len_pend_q <= 1'b0;
      nh_q       <= '0;
      bound_q    <= '0;
    end else if (acc && sof_i) begin
      busy_q     <= !fin;
      first_q    <= 1'b1;
      len_pend_q <= 1'b0;
      bound_q    <= BASE_POS;
    end else if (cont) begin
      if (fin) busy_q <= 1'b0;
      if (at_nh) nh_q <= data_i;
      if (at_bound && is_ext && !hop_bad) begin
        nh_q       <= data_i;
        len_pend_q <= 1'b1;
        first_q    <= 1'b0;
      end
      if (at_len) begin
        len_pend_q <= 1'b0;
        bound_q    <= sum[OFF_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      ptype_o   <= PT_OTHER;
      err_o     <= 1'b0;
      csum_ok_o <= 1'b0;
      offset_o  <= '0;
    end else begin
      done_o <= fin;
      if (fin) begin
        ptype_o   <= fin_ok ? cls_i.pt : PT_OTHER;
        err_o     <= !fin_ok;
        csum_ok_o <= fin_ok && (cls_i.pt != PT_OTHER);
        offset_o  <= fin_ok ? pos_i : '0;
      end
    end
  end
endmodule

// File: rtl/ipv6_chain_walker.sv
module ipv6_chain_walker
  import ipv6_chain_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic [7:0]       data_i,
  output logic             done_o,
  output logic [1:0]       ptype_o,
  output logic             err_o,
  output logic             csum_ok_o,
  output logic [OFF_W-1:0] offset_o
);
  logic [OFF_W-1:0] pos;
  logic [7:0]       nh;
  nh_class_t        cls;
  ptype_e           pt;

  ipv6_byte_pos #(.OFF_W(OFF_W)) u_pos (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sof_i   (sof_i),
    .pos_o   (pos)
  );

  ipv6_nh_classify u_cls (
    .code_i (nh),
    .cls_o  (cls)
  );

  ipv6_chain_fsm #(.OFF_W(OFF_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .sof_i     (sof_i),
    .eof_i     (eof_i),
    .data_i    (data_i),
    .pos_i     (pos),
    .cls_i     (cls),
    .nh_o      (nh),
    .done_o    (done_o),
    .ptype_o   (pt),
    .err_o     (err_o),
    .csum_ok_o (csum_ok_o),
    .offset_o  (offset_o)
  );

  assign ptype_o = pt;
endmodule

// File: rtl/ipv6_chain_check.sv
module ipv6_chain_check #(
  parameter int OFF_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             done_o,
  input logic [1:0]       ptype_o,
  input logic             err_o,
  input logic             csum_ok_o,
  input logic [OFF_W-1:0] offset_o
);
  assert_idle_no_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);

  assert_err_is_other_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ptype_o == 2'd0));

  assert_err_zero_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (offset_o == '0));

  assert_csum_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csum_ok_o |-> (!err_o && ptype_o != 2'd0));

  assert_off_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (offset_o[2:0] == 3'd0 && offset_o >= OFF_W'(40)));

  assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({ptype_o, err_o, csum_ok_o, offset_o}) |-> done_o);
endmodule

bind ipv6_chain_walker ipv6_chain_check #(.OFF_W(OFF_W)) u_check (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .done_o    (done_o),
  .ptype_o   (ptype_o),
  .err_o     (err_o),
  .csum_ok_o (csum_ok_o),
  .offset_o  (offset_o)
);

// File: tb/ipv6_chain_walker_test.sv
module ipv6_chain_walker_test;
  localparam int OFF_W = 10;
  localparam int BUF   = 1024;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic valid = 1'b0, sof = 1'b0, eof = 1'b0;
  logic [7:0] data = '0;
  logic done_o, err_o, csum_ok_o;
  logic [1:0] ptype_o;
  logic [OFF_W-1:0] offset_o;

  ipv6_chain_walker #(.OFF_W(OFF_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .sof_i(sof), .eof_i(eof),
    .data_i(data), .done_o(done_o), .ptype_o(ptype_o), .err_o(err_o),
    .csum_ok_o(csum_ok_o), .offset_o(offset_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic [7:0] fb [BUF];
  int flen, cur;
  int got_n, got_idx, got_pt, got_off;
  bit got_err, got_csum;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sample_out(int idx);
    if (done_o) begin
      got_n++; got_idx = idx; got_pt = int'(ptype_o); got_err = err_o;
      got_off = int'(offset_o); got_csum = csum_ok_o;
    end
  endtask

  task automatic send(bit gaps, bit with_eof);
    got_n = 0; got_idx = -1;
    for (int i = 0; i < flen; i++) begin
      if (gaps && (i % 5 == 2)) begin
        @(negedge clk); sample_out(i - 1);
        valid = 1'b0; sof = 1'b1; eof = 1'b1; data = 8'h00;
      end
      @(negedge clk); sample_out(i - 1);
      valid = 1'b1; sof = (i == 0); eof = with_eof && (i == flen - 1); data = fb[i];
    end
    @(negedge clk); sample_out(flen - 1);
    valid = 1'b0; sof = 1'b0; eof = 1'b0;
    repeat (2) begin @(negedge clk); sample_out(-100); end
  endtask

  task automatic base(logic [7:0] nh);
    for (int i = 0; i < 40; i++) fb[i] = 8'(i * 13 + 5);
    fb[6] = nh;
    cur = 40;
  endtask

  task automatic ext(logic [7:0] nxt, int len);
    fb[cur] = nxt;
    fb[cur + 1] = 8'(len);
    for (int i = 2; i < (len + 1) * 8; i++) fb[cur + i] = 8'(i * 7 + 1);
    cur += (len + 1) * 8;
  endtask

  task automatic pay(int n);
    for (int i = 0; i < n; i++) fb[cur + i] = 8'(i + 200);
    flen = cur + n;
  endtask

  task automatic verify(string req, int exp_idx, int exp_pt, bit exp_err, int exp_off);
    chk(got_n == 1, "R9", "done count", got_n, 1);
    chk(got_idx == exp_idx, req, "deciding byte", got_idx, exp_idx);
    chk(got_pt == exp_pt, req, "ptype", got_pt, exp_pt);
    chk(got_err == exp_err, req, "err", int'(got_err), int'(exp_err));
    chk(got_off == exp_off, exp_err ? "R11" : req, "offset", got_off, exp_off);
    chk(got_csum == (exp_pt != 0 && !exp_err), "R6", "csum_ok", int'(got_csum),
        int'(exp_pt != 0 && !exp_err));
  endtask

  function automatic logic [7:0] ext_code(int sel);
    return (sel == 0) ? 8'd0 : (sel == 1) ? 8'd43 : 8'd60;
  endfunction

  function automatic logic [7:0] fin_code(int sel);
    return (sel == 0) ? 8'd6 : (sel == 1) ? 8'd17 : (sel == 2) ? 8'd58 : 8'd59;
  endfunction

  function automatic int fin_pt(int sel);
    return (sel == 3) ? 0 : sel + 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!done_o && ptype_o == 0 && !err_o && !csum_ok_o && offset_o == 0, "R1",
        "reset outputs", int'({done_o, ptype_o, err_o, csum_ok_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!done_o && offset_o == 0, "R1", "after release", int'(done_o), 0);

    // sweep: up to three extension headers, every code combination, four terminals
    for (int ns = 0; ns <= 3; ns++) begin
      int ncomb = (ns == 0) ? 1 : (ns == 1) ? 3 : (ns == 2) ? 9 : 27;
      for (int cb = 0; cb < ncomb; cb++) begin
        for (int fs = 0; fs < 4; fs++) begin
          logic [7:0] codes [3];
          int starts [3];
          int bad, div, pend;
          string tag;
          div = 1; bad = -1;
          for (int k = 0; k < 3; k++) begin
            codes[k] = ext_code((cb / div) % 3);
            div *= 3;
            starts[k] = 0;
          end
          base((ns == 0) ? fin_code(fs) : codes[0]);
          for (int k = 0; k < ns; k++) begin
            starts[k] = cur;
            ext((k + 1 < ns) ? codes[k + 1] : fin_code(fs), (k * 5 + cb + fs) % 4);
            if (k >= 1 && codes[k] == 8'd0 && bad < 0) bad = k;
          end
          pend = cur;
          pay(8);
          send(((cb + fs) % 2) == 1, 1'b1);
          if (bad >= 0) tag = "R5";
          else if (fs == 3) tag = "R6";
          else if (ns == 0) tag = "R2";
          else if (codes[0] == 8'd0) tag = "R4";
          else tag = "R3";
          if (bad >= 0) verify(tag, starts[bad], 0, 1'b1, 0);
          else verify(tag, pend, fin_pt(fs), 1'b0, pend);
        end
      end
    end

    // R3: one long destination-options header
    base(8'd60); ext(8'd6, 100); pay(2); send(1'b0, 1'b1);
    verify("R3", 848, 1, 1'b0, 848);

    // R7: end of packet exactly before the payload, inside a header, and a 1-byte packet
    base(8'd6); pay(0); send(1'b0, 1'b1);
    verify("R7", 39, 0, 1'b1, 0);
    base(8'd43); ext(8'd17, 2); flen = 45; send(1'b0, 1'b1);
    verify("R7", 44, 0, 1'b1, 0);
    base(8'd17); flen = 1; send(1'b0, 1'b1);
    verify("R7", 0, 0, 1'b1, 0);

    // R10: header end past the offset range, flagged on the length byte
    base(8'd60); fb[40] = 8'd6; fb[41] = 8'd255;
    for (int i = 42; i < 60; i++) fb[i] = 8'h11;
    flen = 60; send(1'b0, 1'b1);
    verify("R10", 41, 0, 1'b1, 0);

    // R9: abandoned packet without end mark, then a fresh one
    base(8'd17); flen = 20; send(1'b0, 1'b0);
    chk(got_n == 0, "R9", "abandoned packet result", got_n, 0);
    base(8'd43); ext(8'd17, 0); pay(30); send(1'b0, 1'b1);
    verify("R9", 48, 2, 1'b0, 48);

    // R8: gaps carrying stray start/end marks and a hop-by-hop code on the data lines
    base(8'd43); ext(8'd58, 1); pay(5); send(1'b1, 1'b1);
    verify("R8", 56, 3, 1'b0, 56);

    finish_run();
  end
endmodule